// File: doc/BRIEF.md
# Dual-Slope and Single-Slope PWM Timer

An 8-bit timer/counter with a waveform generator driving two output pins. It has two kinds of PWM. The phase-correct kind counts from zero up to a TOP value and back down again. It drives each pin low or high on the compare match, and the edge it picks depends on whether the counter is rising or falling, so the pulse stays centred in the period. The fast kind counts from zero up to TOP and wraps. It changes the pin at the wrap and at the compare match, or toggles the pin on every match.

The counter moves only when the timer clock enable (`tick`) is high, so an outside prescaler sets the rate. Each of the two channels has a compare value that is double buffered. A write goes to a holding register, and the active value copies it only at TOP in phase-correct mode or at the wrap in fast mode. The waveform therefore never shows a glitch in the middle of a period.

The mode codes are 1 (phase-correct, TOP = 255), 3 (fast, TOP = 255), 5 (phase-correct, TOP = active compare A) and 7 (fast, TOP = active compare A). Any other code stops the counter. Each channel has its own output code: 0 off, 1 toggle, 2 non-inverting, 3 inverting.

Top module: `pwm_dual_slope_timer`

## Requirements
- R1: Reset clears the counter, both waveforms, all flags, the configuration (mode 0, output codes 0) and the compare values. The counter changes only on clock cycles where `tick` is 1.
- R2: In mode 1 the counter steps by exactly one on each tick, 0 up to 255 and back to 0. It shows 255 for a single tick, so one period is 510 ticks.
- R3: In mode 5 TOP is the active compare A value. With A = 50 the counter peaks at 50, and with B = 20 and output code 2, channel B is high for 40 ticks of each 100.
- R4: In phase-correct mode with output code 2, a match while rising drives the pin low and a match while falling drives it high. With compare N (0 < N < TOP) the pin is high for 2N ticks per period.
- R5: In phase-correct mode with output code 3, the edges are the opposite of R4. With compare N the pin is high for 2·TOP − 2N ticks per period.
- R6: In phase-correct mode with output code 2, compare 0 keeps the pin low and compare TOP keeps it high. A match at 0 counts as rising and a match at TOP counts as falling.
- R7: In modes 3 and 7 the counter runs 0 up to TOP and then returns to 0, never exceeding TOP. With output code 2 the pin goes high at the wrap and low at the match, so it is high for N+1 ticks per period. Code 3 gives the inverse.
- R8: In fast mode with output code 1 the pin toggles on every match. In mode 7 with A = 0 the counter stays at 0 and pin A flips on every tick.
- R9: While the timer runs, a compare write changes only the holding register. The active value takes it over at the TOP tick (phase-correct) or at the wrap tick (fast).
- R10: The overflow flag is high for one clock after the tick where the counter turns at 0 in phase-correct mode (the count then reads 1), or after the wrap tick in fast mode (the count then reads 0).
- R11: A channel's match flag is high for one clock after each tick where the counter equals that channel's active compare value.
- R12: With output code 0 the pin is driven low. Mode codes 0, 2, 4 and 6 freeze the counter and the pins, and copy each holding register straight into its active value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable from the prescaler |
| cfg_we | input | 1 | Write strobe for the mode and the output codes |
| cfg_mode | input | 3 | Waveform mode code |
| cfg_out_a | input | 2 | Output code for channel A |
| cfg_out_b | input | 2 | Output code for channel B |
| cmp_a_we | input | 1 | Write strobe for the compare A holding register |
| cmp_a_din | input | CNT_W | Compare A write data |
| cmp_b_we | input | 1 | Write strobe for the compare B holding register |
| cmp_b_din | input | CNT_W | Compare B write data |
| count | output | CNT_W | Current counter value |
| wave_a | output | 1 | Waveform pin A |
| wave_b | output | 1 | Waveform pin B |
| ovf_flag | output | 1 | Overflow (bottom or wrap) pulse |
| match_a_flag | output | 1 | Channel A compare-match pulse |
| match_b_flag | output | 1 | Channel B compare-match pulse |

## Verification
The bench targets the two extremes of phase-correct compare. If a match at 0 or at TOP were given the wrong direction, the pin would give a one-tick spike instead of a steady level. It checks that the counter holds 255 for one tick only; a design that held TOP twice, or skipped it, would add a tick to the period or remove one, and the duty counts would drift. It writes a new compare value midway up the slope and expects the old value to give the next match and the new value to give the match after TOP. A design without the buffer would match at the new value straight away. It also checks the half-rate toggle with TOP = 0, the single-tick pulse position of the overflow flag in both kinds of PWM, and that the counter stops when `tick` is low or the mode code is not a PWM code.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [2:0] {
    WG_STOP0     = 3'd0,
    WG_PC_FULL   = 3'd1,
    WG_STOP2     = 3'd2,
    WG_FAST_FULL = 3'd3,
    WG_STOP4     = 3'd4,
    WG_PC_CMPA   = 3'd5,
    WG_STOP6     = 3'd6,
    WG_FAST_CMPA = 3'd7
  } wg_mode_t;

  typedef enum logic [1:0] {
    OUT_OFF    = 2'd0,
    OUT_TOGGLE = 2'd1,
    OUT_NONINV = 2'd2,
    OUT_INV    = 2'd3
  } out_mode_t;

  function automatic logic mode_is_dual(wg_mode_t m);
    return (m == WG_PC_FULL) || (m == WG_PC_CMPA);
  endfunction

  function automatic logic mode_is_single(wg_mode_t m);
    return (m == WG_FAST_FULL) || (m == WG_FAST_CMPA);
  endfunction

  function automatic logic mode_top_from_a(wg_mode_t m);
    return (m == WG_PC_CMPA) || (m == WG_FAST_CMPA);
  endfunction

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cfg_we,
  input  logic [2:0] cfg_mode,
  input  logic [1:0] cfg_out_a,
  input  logic [1:0] cfg_out_b,
  output wg_mode_t  mode_o,
  output out_mode_t out_a_o,
  output out_mode_t out_b_o
);

  wg_mode_t  mode_q;
  out_mode_t out_a_q;
  out_mode_t out_b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= WG_STOP0;
      out_a_q <= OUT_OFF;
      out_b_q <= OUT_OFF;
    end else if (cfg_we) begin
      mode_q  <= wg_mode_t'(cfg_mode);
      out_a_q <= out_mode_t'(cfg_out_a);
      out_b_q <= out_mode_t'(cfg_out_b);
    end
  end

  assign mode_o  = mode_q;
  assign out_a_o = out_a_q;
  assign out_b_o = out_b_q;

endmodule

// File: rtl/pwm_slope_counter.sv
module pwm_slope_counter
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  wg_mode_t         mode_i,
  input  logic [CNT_W-1:0] top_a_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_phase_o,
  output logic             run_o,
  output logic             single_o,
  output logic             load_o,
  output logic             wrap_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d, top_val;
  logic             dir_q, dir_d;
  logic             ovf_q;
  logic             dual, single, at_top, at_bot;
  logic             turn_top, turn_bot;

  assign dual    = mode_is_dual(mode_i);
  assign single  = mode_is_single(mode_i);
  assign top_val = mode_top_from_a(mode_i) ? top_a_i : MAXV;
  assign at_top  = (cnt_q >= top_val);
  assign at_bot  = (cnt_q == ZERO);

  always_comb begin
    cnt_d    = cnt_q;
    dir_d    = dir_q;
    turn_top = 1'b0;
    turn_bot = 1'b0;
    if (single) begin
      dir_d = 1'b0;
      if (at_top) begin
        cnt_d    = ZERO;
        turn_top = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else if (dual) begin
      if (!dir_q) begin
        if (at_top) begin
          dir_d    = 1'b1;
          turn_top = 1'b1;
          cnt_d    = at_bot ? ZERO : (cnt_q - ONE);
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (at_bot) begin
          dir_d    = 1'b0;
          turn_bot = 1'b1;
          cnt_d    = (top_val == ZERO) ? ZERO : ONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ZERO;
      dir_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= tick & (single ? turn_top : turn_bot);
      if (tick) begin
        cnt_q <= cnt_d;
        dir_q <= dir_d;
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign up_phase_o = at_bot || (!dir_q && !at_top);
  assign run_o      = dual | single;
  assign single_o   = single;
  assign load_o     = tick & turn_top;
  assign wrap_o     = tick & single & turn_top;
  assign ovf_o      = ovf_q;

  // R1: without a tick the count does not move
  a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));

  // R2: dual-slope counting moves by exactly one per tick
  a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
    (tick && dual && top_val != ZERO && cnt_q <= top_val)
      |=> ((cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE)));

  // R7: single-slope counting never passes TOP
  a_r7_within_top: assert property (@(posedge clk) disable iff (rst)
    (tick && single) |=> (cnt_q <= $past(top_val)));

  // R10: dual-slope overflow only after a bottom tick
  a_r10_ovf_at_bottom: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && $past(dual)) |-> ($past(cnt_q) == ZERO));

endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run_i,
  input  logic             single_i,
  input  logic             load_i,
  input  logic             wrap_i,
  input  logic             up_phase_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] din_i,
  input  out_mode_t        com_i,
  output logic [CNT_W-1:0] act_o,
  output logic             wave_o,
  output logic             match_o
);

  logic [CNT_W-1:0] buf_q, act_q;
  logic             wave_q, wave_d, match_q, hit;

  assign hit = (cnt_i == act_q);

  always_comb begin
    wave_d = wave_q;
    if (com_i == OUT_OFF) begin
      wave_d = 1'b0;
    end else if (tick && run_i) begin
      if (single_i) begin
        case (com_i)
          OUT_TOGGLE: if (hit) wave_d = ~wave_q;
          OUT_NONINV: begin
            if (wrap_i)   wave_d = 1'b1;
            else if (hit) wave_d = 1'b0;
          end
          OUT_INV: begin
            if (wrap_i)   wave_d = 1'b0;
            else if (hit) wave_d = 1'b1;
          end
          default: wave_d = 1'b0;
        endcase
      end else begin
        case (com_i)
          OUT_NONINV: if (hit) wave_d = ~up_phase_i;
          OUT_INV:    if (hit) wave_d = up_phase_i;
          default:    wave_d = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q   <= '0;
      act_q   <= '0;
      wave_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      if (wr_i) buf_q <= din_i;
      if (!run_i || load_i) act_q <= buf_q;
      match_q <= tick & run_i & hit;
      wave_q  <= wave_d;
    end
  end

  assign act_o   = act_q;
  assign wave_o  = wave_q;
  assign match_o = match_q;

  // R9: active value holds between update points while running
  a_r9_active_held: assert property (@(posedge clk) disable iff (rst)
    (run_i && !load_i) |=> $stable(act_q));

  // R11: a flag follows only a real equality
  a_r11_flag_on_equal: assert property (@(posedge clk) disable iff (rst)
    match_q |-> ($past(cnt_i) == $past(act_q)));

  // R12: output code off keeps the pin low
  a_r12_off_low: assert property (@(posedge clk) disable iff (rst)
    (com_i == OUT_OFF) |=> !wave_q);

endmodule

// File: rtl/pwm_dual_slope_timer.sv
module pwm_dual_slope_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_mode,
  input  logic [1:0]       cfg_out_a,
  input  logic [1:0]       cfg_out_b,
  input  logic             cmp_a_we,
  input  logic [CNT_W-1:0] cmp_a_din,
  input  logic             cmp_b_we,
  input  logic [CNT_W-1:0] cmp_b_din,
  output logic [CNT_W-1:0] count,
  output logic             wave_a,
  output logic             wave_b,
  output logic             ovf_flag,
  output logic             match_a_flag,
  output logic             match_b_flag
);

  localparam int NCH = 2;

  wg_mode_t         mode;
  out_mode_t        out_a, out_b;
  logic [CNT_W-1:0] cnt;
  logic             up_phase, run, single, load, wrap;

  logic             we_v    [NCH];
  logic [CNT_W-1:0] din_v   [NCH];
  out_mode_t        com_v   [NCH];
  logic [CNT_W-1:0] act_v   [NCH];
  logic             wave_v  [NCH];
  logic             match_v [NCH];

  pwm_cfg_regs u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_mode  (cfg_mode),
    .cfg_out_a (cfg_out_a),
    .cfg_out_b (cfg_out_b),
    .mode_o    (mode),
    .out_a_o   (out_a),
    .out_b_o   (out_b)
  );

  pwm_slope_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .mode_i     (mode),
    .top_a_i    (act_v[0]),
    .cnt_o      (cnt),
    .up_phase_o (up_phase),
    .run_o      (run),
    .single_o   (single),
    .load_o     (load),
    .wrap_o     (wrap),
    .ovf_o      (ovf_flag)
  );

  assign we_v[0]  = cmp_a_we;
  assign we_v[1]  = cmp_b_we;
  assign din_v[0] = cmp_a_din;
  assign din_v[1] = cmp_b_din;
  assign com_v[0] = out_a;
  assign com_v[1] = out_b;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    pwm_cmp_channel #(.CNT_W(CNT_W)) u_ch (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .run_i      (run),
      .single_i   (single),
      .load_i     (load),
      .wrap_i     (wrap),
      .up_phase_i (up_phase),
      .cnt_i      (cnt),
      .wr_i       (we_v[ch]),
      .din_i      (din_v[ch]),
      .com_i      (com_v[ch]),
      .act_o      (act_v[ch]),
      .wave_o     (wave_v[ch]),
      .match_o    (match_v[ch])
    );
  end

  assign count        = cnt;
  assign wave_a       = wave_v[0];
  assign wave_b       = wave_v[1];
  assign match_a_flag = match_v[0];
  assign match_b_flag = match_v[1];

endmodule

// File: tb/tb_pwm_dual_slope_timer.sv
module tb_pwm_dual_slope_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic [1:0] cfg_out_a = 2'd0;
  logic [1:0] cfg_out_b = 2'd0;
  logic       cmp_a_we = 1'b0;
  logic [7:0] cmp_a_din = 8'd0;
  logic       cmp_b_we = 1'b0;
  logic [7:0] cmp_b_din = 8'd0;
  logic [7:0] count;
  logic       wave_a, wave_b, ovf_flag, match_a_flag, match_b_flag;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwm_dual_slope_timer #(.CNT_W(8)) dut (
    .clk(clk), .rst(rst), .tick(tick),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_out_a(cfg_out_a), .cfg_out_b(cfg_out_b),
    .cmp_a_we(cmp_a_we), .cmp_a_din(cmp_a_din), .cmp_b_we(cmp_b_we), .cmp_b_din(cmp_b_din),
    .count(count), .wave_a(wave_a), .wave_b(wave_b), .ovf_flag(ovf_flag),
    .match_a_flag(match_a_flag), .match_b_flag(match_b_flag)
  );

  task automatic chk(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b1; cfg_we = 1'b0; cmp_a_we = 1'b0; cmp_b_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_cmp(input int a, input int b);
    @(negedge clk);
    cmp_a_we = 1'b1; cmp_a_din = 8'(a);
    cmp_b_we = 1'b1; cmp_b_din = 8'(b);
    @(negedge clk);
    cmp_a_we = 1'b0; cmp_b_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_b(input int b);
    cmp_b_we = 1'b1; cmp_b_din = 8'(b);
    @(negedge clk);
    cmp_b_we = 1'b0;
  endtask

  task automatic set_cfg(input int m, input int oa, input int ob);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = 3'(m); cfg_out_a = 2'(oa); cfg_out_b = 2'(ob);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic count_high(input int n, output int ha, output int hb);
    ha = 0; hb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ha += int'(wave_a);
      hb += int'(wave_b);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset count", int'(count), 0);
    chk("R1 reset waves", int'(wave_a) + int'(wave_b), 0);
    chk("R1 reset flags", int'(ovf_flag) + int'(match_a_flag) + int'(match_b_flag), 0);
    repeat (8) @(negedge clk);
    chk("R12 mode 0 after reset holds count", int'(count), 0);
  endtask

  task automatic t_tick_gate();
    int c0;
    do_reset();
    set_cmp(100, 100);
    set_cfg(1, 2, 2);
    repeat (10) @(negedge clk);
    tick = 1'b0;
    c0 = int'(count);
    repeat (5) @(negedge clk);
    chk("R1 count frozen with tick low", int'(count), c0);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk("R1 one tick one step", int'(count), c0 + 1);
    repeat (3) @(negedge clk);
    chk("R1 still frozen", int'(count), c0 + 1);
    tick = 1'b1;
  endtask

  task automatic t_pc_shape();
    int prev, d, bad, n255, mx;
    bad = 0; n255 = 0; mx = 0;
    do_reset();
    set_cmp(0, 0);
    set_cfg(1, 0, 0);
    for (int i = 0; i < 600; i++) begin
      prev = int'(count);
      @(negedge clk);
      d = int'(count) - prev;
      if (d != 1 && d != -1) bad++;
      if (count == 8'd255) n255++;
      if (int'(count) > mx) mx = int'(count);
    end
    chk("R2 unit steps", bad, 0);
    chk("R2 top held one tick", n255, 1);
    chk("R2 peak", mx, 255);
  endtask

  task automatic t_pc_duty();
    int ha, hb;
    do_reset();
    set_cmp(100, 100);
    set_cfg(1, 3, 2);
    repeat (520) @(negedge clk);
    count_high(510, ha, hb);
    chk("R4 non-inverting high ticks", hb, 200);
    chk("R5 inverting high ticks", ha, 310);
    do_reset();
    set_cmp(0, 255);
    set_cfg(1, 2, 2);
    repeat (520) @(negedge clk);
    count_high(510, ha, hb);
    chk("R6 compare 0 stays low", ha, 0);
    chk("R6 compare TOP stays high", hb, 510);
  endtask

  task automatic t_top_a();
    int mx, n50, ha, hb;
    mx = 0; n50 = 0;
    do_reset();
    set_cmp(50, 20);
    set_cfg(5, 0, 2);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (int'(count) > mx) mx = int'(count);
      if (count == 8'd50) n50++;
    end
    chk("R3 peak equals compare A", mx, 50);
    chk("R3 top visits", n50, 2);
    count_high(100, ha, hb);
    chk("R3 channel B duty with TOP 50", hb, 40);
  endtask

  task automatic t_fast();
    int prev, bad, mx, ha, hb;
    bad = 0; mx = 0;
    do_reset();
    set_cmp(63, 63);
    set_cfg(3, 3, 2);
    for (int i = 0; i < 300; i++) begin
      prev = int'(count);
      @(negedge clk);
      if (prev == 255 && count != 8'd0) bad++;
      if (prev != 255 && int'(count) != prev + 1) bad++;
      if (int'(count) > mx) mx = int'(count);
    end
    chk("R7 ramp and wrap", bad, 0);
    chk("R7 peak", mx, 255);
    count_high(256, ha, hb);
    chk("R7 non-inverting high ticks", hb, 64);
    chk("R7 inverting high ticks", ha, 192);
    do_reset();
    set_cmp(99, 0);
    set_cfg(7, 0, 0);
    mx = 0;
    for (int i = 0; i < 250; i++) begin
      @(negedge clk);
      if (int'(count) > mx) mx = int'(count);
    end
    chk("R7 mode 7 peak equals compare A", mx, 99);
  endtask

  task automatic t_toggle();
    int bad;
    logic prev;
    bad = 0;
    do_reset();
    set_cmp(0, 0);
    set_cfg(7, 1, 0);
    repeat (3) @(negedge clk);
    prev = wave_a;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (wave_a == prev) bad++;
      if (count != 8'd0) bad++;
      prev = wave_a;
    end
    chk("R8 toggle every tick", bad, 0);
  endtask

  task automatic t_buffer();
    int got[2];
    int n, guard;
    n = 0; guard = 0;
    got[0] = -1; got[1] = -1;
    do_reset();
    set_cmp(100, 100);
    set_cfg(1, 0, 0);
    while (count != 8'd20 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    write_b(200);
    for (int i = 0; i < 600; i++) begin
      if (match_b_flag && n < 2) begin
        got[n] = int'(count);
        n++;
      end
      @(negedge clk);
    end
    chk("R9 old value still active before TOP", got[0], 101);
    chk("R9 new value after TOP (R11 flag)", got[1], 199);
  endtask

  task automatic t_ovf();
    int t0, t1, c0, cyc;
    t0 = -1; t1 = -1; c0 = -1; cyc = 0;
    do_reset();
    set_cmp(0, 0);
    set_cfg(1, 0, 0);
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      cyc++;
      if (ovf_flag) begin
        if (t0 < 0) begin t0 = cyc; c0 = int'(count); end
        else if (t1 < 0) t1 = cyc;
      end
    end
    chk("R10 dual count at flag", c0, 1);
    chk("R10 dual flag interval", t1 - t0, 510);
    t0 = -1; t1 = -1; c0 = -1; cyc = 0;
    do_reset();
    set_cfg(3, 0, 0);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      cyc++;
      if (ovf_flag) begin
        if (t0 < 0) begin t0 = cyc; c0 = int'(count); end
        else if (t1 < 0) t1 = cyc;
      end
    end
    chk("R10 single count at flag", c0, 0);
    chk("R10 single flag interval", t1 - t0, 256);
  endtask

  task automatic t_off_halt();
    int ha, hb, c0;
    logic wb;
    do_reset();
    set_cmp(100, 100);
    set_cfg(1, 0, 2);
    count_high(600, ha, hb);
    chk("R12 output code 0 low", ha, 0);
    set_cfg(2, 0, 2);
    c0 = int'(count);
    wb = wave_b;
    repeat (20) @(negedge clk);
    chk("R12 stop code freezes count", int'(count), c0);
    chk("R12 stop code freezes pin", int'(wave_b), int'(wb));
  endtask

  initial begin
    t_reset();
    t_tick_gate();
    t_pc_shape();
    t_pc_duty();
    t_top_a();
    t_fast();
    t_toggle();
    t_buffer();
    t_ovf();
    t_off_halt();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule